// File: doc/BRIEF.md
# UART Control and Status Register Block

This block is the software-visible register front end of a 16550-style serial port. A host reaches it through a simple 16-bit register bus in which registers are spaced four bytes apart. It holds the line, modem, scratch and global control bytes, the interrupt enables and the two divisor bytes. It hands each byte written for transmission to a transmitter as a one-cycle strobe, and it keeps the last byte delivered by a receiver until the host reads it. The shift logic, the baud generator and any FIFOs live outside this block.

Bit 7 of the line control register selects the divisor-access mode. In that mode the two lowest register slots reach the divisor bytes. Otherwise the lowest slot is the data port and the next slot holds the interrupt enables. The line status register merges a set of stored flags with the live status, and a read clears the stored flags. A loopback mode in the modem control register routes each transmitted byte back into the receive hold and disconnects the external receive input. Two event outputs tell an interrupt controller that a byte was sent or that a byte is waiting, each gated by its own enable.

Top module: `uart_regblk`

## Requirements
- R1: Every cycle with `bus_sel` high is answered one cycle later by `bus_ack` high for exactly that cycle, carrying `bus_err` and `bus_rdata`. `bus_ack` is never high otherwise.
- R2: An access raises `bus_err` and has no effect on any register or output if `bus_size16` is low, if the low two address bits are non-zero, or if the register index (address bits 5:2) is 8 or greater than 9. An erroneous access returns read data 0.
- R3: When line control bit 7 is set, index 0 reads and writes the low divisor byte (reset 0x01) and index 1 reads and writes the high divisor byte (reset 0x00). A write to index 0 in this mode starts no transmission.
- R4: When line control bit 7 is clear, a write to index 0 produces `tx_valid` high for one cycle, in the response cycle, with `tx_byte` equal to write data bits 7:0.
- R5: When line control bit 7 is clear, index 1 reads and writes the 8-bit interrupt-enable register (reset 0x00).
- R6: Index 2 (interrupt identification) reads 0x01 and index 6 (modem status) reads 0x00, and writes to either index have no effect. Indices 3, 4, 7 and 9 (line control, modem control, scratch, global control) store write data bits 7:0 and read them back. All reset to 0x00.
- R7: Bits 15:8 of every read return zero, and write data bits 15:8 are discarded.
- R8: A read of index 5 (line status) returns the stored flags ORed with the live status. The live status has bit 0 set while a received byte is waiting and bits 5 and 6 equal to `tx_idle`. The stored flags reset to 0x60 and clear to 0x00 after each line status read. Writes to index 5 have no effect.
- R9: With loopback off (modem control bit 4 clear), `rx_valid` stores `rx_byte` and sets the data-ready flag. A read of index 0 with line control bit 7 clear returns the held byte and clears the flag. A byte arriving in the same cycle as such a read is kept, and the flag stays set.
- R10: With loopback on, each transmit write also stores its byte as the received byte and sets the data-ready flag, and `rx_valid` is ignored.
- R11: `tx_event` is high in exactly the cycles where `tx_valid` is high and interrupt-enable bit 1 is set.
- R12: `rx_event` is high exactly while the data-ready flag is set and interrupt-enable bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address within the block |
| bus_size16 | input | 1 | Access is 16 bits wide |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | Response valid |
| bus_err | output | 1 | Error response |
| bus_rdata | output | 16 | Read data |
| tx_byte | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit strobe |
| tx_idle | input | 1 | Transmitter holding and shift stages empty |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| tx_event | output | 1 | Transmit interrupt event |
| rx_event | output | 1 | Receive interrupt event |

## Verification
The hardest case to reach is a receive arrival that lands in the same cycle as a host read of the data port. The read must return the old byte while the new byte and its ready flag survive. Random stimulus almost never lines these up, so the access task can drive a receive strobe alongside a bus request, and directed steps use it both with loopback off and with loopback on, where the strobe must be ignored. The random phase mixes legal and illegal addresses, narrow accesses, toggles of divisor-access and loopback mode, and a changing transmitter-idle level, all against a bench register model.

// File: rtl/uart_regblk_pkg.sv
// Package: shared constants and types for the UART register block.
// Assumes a 4-byte register stride and 8 implemented bits per register.
package uart_regblk_pkg;

    localparam int STRIDE_LOG2 = 2;
    localparam int IDX_W       = 4;

    // Register slot indices (address bits 5:2)
    localparam logic [IDX_W-1:0] IX_DATA = 4'd0;
    localparam logic [IDX_W-1:0] IX_IEN  = 4'd1;
    localparam logic [IDX_W-1:0] IX_IID  = 4'd2;
    localparam logic [IDX_W-1:0] IX_LCTL = 4'd3;
    localparam logic [IDX_W-1:0] IX_MCTL = 4'd4;
    localparam logic [IDX_W-1:0] IX_LSTS = 4'd5;
    localparam logic [IDX_W-1:0] IX_MSTS = 4'd6;
    localparam logic [IDX_W-1:0] IX_SCR  = 4'd7;
    localparam logic [IDX_W-1:0] IX_HOLE = 4'd8;
    localparam logic [IDX_W-1:0] IX_GCTL = 4'd9;

    // Bit positions
    localparam int LSTS_READY_BIT = 0;
    localparam int LSTS_HEMPTY_BIT = 5;
    localparam int LSTS_IDLE_BIT  = 6;
    localparam int IEN_RX_BIT     = 0;
    localparam int IEN_TX_BIT     = 1;
    localparam int LCTL_DIVACC_BIT = 7;
    localparam int MCTL_LOOP_BIT  = 4;

    // Number of plain read/write storage registers
    localparam int N_PLAIN = 4;

    // Slot index of plain register k (line ctl, modem ctl, scratch, global ctl)
    function automatic logic [IDX_W-1:0] plain_slot(input int k);
        case (k)
            0:       plain_slot = IX_LCTL;
            1:       plain_slot = IX_MCTL;
            2:       plain_slot = IX_SCR;
            default: plain_slot = IX_GCTL;
        endcase
    endfunction

    // Registered bus response
    typedef struct packed {
        logic        ack;
        logic        err;
        logic [15:0] data;
    } bus_resp_t;

endpackage

// File: rtl/uart_rb_decode.sv
// Module: address and size decoder for the register block.
// Produces the slot index and an error flag for illegal accesses.
// Assumes the byte address is word aligned on the register stride.
module uart_rb_decode
    import uart_regblk_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              size16,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              bad
);

    // Slot index and legality check
    always_comb begin
        idx = addr[STRIDE_LOG2 +: IDX_W];
        bad = 1'b0;
        if (!size16)                          bad = 1'b1;
        if (addr[STRIDE_LOG2-1:0] != '0)      bad = 1'b1;
        if (idx == IX_HOLE || idx > IX_GCTL)  bad = 1'b1;
    end

endmodule

// File: rtl/uart_rb_plain_reg.sv
// Module: one plain read/write control byte.
// Loads the write data when a legal write targets its slot.
// Assumes the write enable is already qualified by the decoder.
module uart_rb_plain_reg
    import uart_regblk_pkg::*;
#(
    parameter int               REG_W = 8,
    parameter logic [IDX_W-1:0] SLOT  = IX_SCR,
    parameter logic [REG_W-1:0] RST   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] q
);

    // Storage update
    always_ff @(posedge clk) begin
        if (!rst_n)                        q <= RST;
        else if (wr_ok && idx == SLOT)     q <= wdata;
    end

endmodule

// File: rtl/uart_rb_rxhold.sv
// Module: one-byte receive hold with data-ready flag and loopback.
// In loopback the transmit write is the only source; the external
// strobe is ignored. A new byte has priority over a read clear.
module uart_rb_rxhold #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_en,
    input  logic             thr_wr,
    input  logic [REG_W-1:0] thr_byte,
    input  logic             rx_valid,
    input  logic [REG_W-1:0] rx_byte,
    input  logic             rbr_rd,
    output logic [REG_W-1:0] rbr_q,
    output logic             ready_q
);

    logic             in_valid;
    logic [REG_W-1:0] in_byte;

    // Select the receive source
    always_comb begin
        in_valid = loop_en ? thr_wr   : rx_valid;
        in_byte  = loop_en ? thr_byte : rx_byte;
    end

    // Hold byte and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbr_q   <= '0;
            ready_q <= 1'b0;
        end else if (in_valid) begin
            rbr_q   <= in_byte;
            ready_q <= 1'b1;
        end else if (rbr_rd) begin
            ready_q <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_regblk.sv
// Module: UART register block top.
// Decodes register accesses, keeps control bytes and divisor, emits
// transmit strobes and events, and answers each access one cycle later.
// Assumes at most one access per cycle; no back-pressure.
module uart_regblk
    import uart_regblk_pkg::*;
#(
    parameter int               ADDR_W     = 6,
    parameter int               BUS_W      = 16,
    parameter int               REG_W      = 8,
    parameter logic [REG_W-1:0] DIVLO_RST  = 8'h01,
    parameter logic [REG_W-1:0] IID_VALUE  = 8'h01,
    parameter logic [REG_W-1:0] LSTS_RST   = 8'h60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_size16,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [REG_W-1:0]  tx_byte,
    output logic              tx_valid,
    input  logic              tx_idle,
    input  logic [REG_W-1:0]  rx_byte,
    input  logic              rx_valid,
    output logic              tx_event,
    output logic              rx_event
);

    localparam int PAD_W = BUS_W - REG_W;

    logic [IDX_W-1:0] idx;
    logic             dec_bad;
    logic             acc_ok, wr_ok, rd_ok;
    logic             divacc;
    logic             thr_wr, rbr_rd, lsts_rd;
    logic [REG_W-1:0] wbyte;
    logic             unused_hi;

    logic [REG_W-1:0] plain_q [N_PLAIN];
    logic [REG_W-1:0] lctl_q, mctl_q;
    logic [REG_W-1:0] divlo_q, divhi_q, ien_q, lsts_q;
    logic [REG_W-1:0] rbr_q;
    logic             rx_ready;
    logic [REG_W-1:0] live_sts;
    logic [REG_W-1:0] rd_mux;
    bus_resp_t        resp_q;
    logic [REG_W-1:0] tx_byte_q;
    logic             tx_valid_q, tx_event_q;

    uart_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .size16 (bus_size16),
        .addr   (bus_addr),
        .idx    (idx),
        .bad    (dec_bad)
    );

    // Access qualification
    always_comb begin
        wbyte   = bus_wdata[REG_W-1:0];
        acc_ok  = bus_sel && !dec_bad;
        wr_ok   = acc_ok && bus_wr;
        rd_ok   = acc_ok && !bus_wr;
        divacc  = lctl_q[LCTL_DIVACC_BIT];
        thr_wr  = wr_ok && idx == IX_DATA && !divacc;
        rbr_rd  = rd_ok && idx == IX_DATA && !divacc;
        lsts_rd = rd_ok && idx == IX_LSTS;
    end

    assign unused_hi = ^bus_wdata[BUS_W-1:REG_W];

    // Plain storage registers
    generate
        for (genvar k = 0; k < N_PLAIN; k++) begin : g_plain
            uart_rb_plain_reg #(
                .REG_W (REG_W),
                .SLOT  (plain_slot(k)),
                .RST   ('0)
            ) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_ok (wr_ok),
                .idx   (idx),
                .wdata (wbyte),
                .q     (plain_q[k])
            );
        end
    endgenerate

    assign lctl_q = plain_q[0];
    assign mctl_q = plain_q[1];

    // Divisor bytes and interrupt enables, aliased on the low slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divlo_q <= DIVLO_RST;
            divhi_q <= '0;
            ien_q   <= '0;
        end else if (wr_ok) begin
            if (idx == IX_DATA && divacc)  divlo_q <= wbyte;
            if (idx == IX_IEN && divacc)   divhi_q <= wbyte;
            if (idx == IX_IEN && !divacc)  ien_q   <= wbyte;
        end
    end

    uart_rb_rxhold #(.REG_W(REG_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .loop_en  (mctl_q[MCTL_LOOP_BIT]),
        .thr_wr   (thr_wr),
        .thr_byte (wbyte),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rbr_rd   (rbr_rd),
        .rbr_q    (rbr_q),
        .ready_q  (rx_ready)
    );

    // Live line status
    always_comb begin
        live_sts                  = '0;
        live_sts[LSTS_READY_BIT]  = rx_ready;
        live_sts[LSTS_HEMPTY_BIT] = tx_idle;
        live_sts[LSTS_IDLE_BIT]   = tx_idle;
    end

    // Stored status flags, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n)       lsts_q <= LSTS_RST;
        else if (lsts_rd) lsts_q <= '0;
    end

    // Read data selection
    always_comb begin
        rd_mux = '0;
        case (idx)
            IX_DATA: rd_mux = divacc ? divlo_q : rbr_q;
            IX_IEN:  rd_mux = divacc ? divhi_q : ien_q;
            IX_IID:  rd_mux = IID_VALUE;
            IX_LCTL: rd_mux = plain_q[0];
            IX_MCTL: rd_mux = plain_q[1];
            IX_LSTS: rd_mux = lsts_q | live_sts;
            IX_MSTS: rd_mux = '0;
            IX_SCR:  rd_mux = plain_q[2];
            IX_GCTL: rd_mux = plain_q[3];
            default: rd_mux = '0;
        endcase
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q.ack  <= bus_sel;
            resp_q.err  <= bus_sel && dec_bad;
            resp_q.data <= rd_ok ? {{PAD_W{1'b0}}, rd_mux} : '0;
        end
    end

    // Transmit strobe and event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte_q  <= '0;
            tx_valid_q <= 1'b0;
            tx_event_q <= 1'b0;
        end else begin
            tx_valid_q <= thr_wr;
            tx_event_q <= thr_wr && ien_q[IEN_TX_BIT];
            if (thr_wr) tx_byte_q <= wbyte;
        end
    end

    assign bus_ack   = resp_q.ack;
    assign bus_err   = resp_q.err;
    assign bus_rdata = resp_q.data;
    assign tx_byte   = tx_byte_q;
    assign tx_valid  = tx_valid_q;
    assign tx_event  = tx_event_q;
    assign rx_event  = rx_ready && ien_q[IEN_RX_BIT];

endmodule

// File: rtl/uart_regblk_chk.sv
// Module: protocol checker for the UART register block, bound to the top.
// Assumes synchronous active-low reset on rst_n.
module uart_regblk_chk #(
    parameter int BUS_W = 16,
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_ack,
    input logic             bus_err,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             tx_valid,
    input logic             tx_event,
    input logic             rx_event,
    input logic [REG_W-1:0] ien_q,
    input logic             rx_ready
);

    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ack);                                  // R1
    AST_ACK_ONLY_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_sel));                           // R1
    AST_ERR_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !tx_valid);                                // R2
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdata == '0);                          // R2
    AST_TXEV_WITH_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_event |-> tx_valid);                                // R11
    AST_RXEV_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_event) |-> ($rose(rx_ready) || $rose(ien_q[0]))); // R12

endmodule

bind uart_regblk uart_regblk_chk #(.BUS_W(BUS_W), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .tx_event  (tx_event),
    .rx_event  (rx_event),
    .ien_q     (ien_q),
    .rx_ready  (rx_ready)
);

// File: tb/uart_regblk_tb.sv
// Bench: directed corners plus seeded random accesses against a register model.
module uart_regblk_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_size16 = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [15:0] bus_rdata;
    logic [7:0]  tx_byte;
    logic        tx_valid, tx_event, rx_event;
    logic        tx_idle = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Model state
    logic [7:0] m_divlo, m_divhi, m_ien, m_lctl, m_mctl, m_scr, m_gctl, m_rbr, m_lsts;
    logic       m_rdy;

    always #10 clk = ~clk;

    uart_regblk u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_size16(bus_size16), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_idle(tx_idle),
        .rx_byte(rx_byte), .rx_valid(rx_valid),
        .tx_event(tx_event), .rx_event(rx_event)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit is_bad(input logic [5:0] a, input bit s16);
        return !s16 || a[1:0] != 2'b00 || a[5:2] == 4'd8 || a[5:2] > 4'd9;
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] i);
        bit dl = m_lctl[7];
        case (i)
            4'd0: return dl ? m_divlo : m_rbr;
            4'd1: return dl ? m_divhi : m_ien;
            4'd2: return 8'h01;
            4'd3: return m_lctl;
            4'd4: return m_mctl;
            4'd5: return m_lsts | {1'b0, tx_idle, tx_idle, 4'b0, m_rdy};
            4'd7: return m_scr;
            4'd9: return m_gctl;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] i);
        case (i)
            4'd0: return m_lctl[7] ? "R3" : "R9";
            4'd1: return m_lctl[7] ? "R3" : "R5";
            4'd5: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic model_reset();
        m_divlo = 8'h01; m_divhi = 0; m_ien = 0; m_lctl = 0; m_mctl = 0;
        m_scr = 0; m_gctl = 0; m_rbr = 0; m_lsts = 8'h60; m_rdy = 0;
    endtask

    // One bus access, optionally with a receive strobe in the same cycle
    task automatic acc(input bit w, input logic [5:0] a, input logic [15:0] d,
                       input bit s16, input bit rxv, input logic [7:0] rxb);
        bit          e_err = is_bad(a, s16);
        logic [3:0]  i = a[5:2];
        bit          dl = m_lctl[7];
        bit          lp = m_mctl[4];
        bit          e_tx = w && !e_err && i == 4'd0 && !dl;
        logic [7:0]  e_rd = (!w && !e_err) ? exp_read(i) : 8'h00;
        string       rq = req_of(i);
        @(negedge clk);
        bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d; bus_size16 = s16;
        rx_valid = rxv; rx_byte = rxb;
        @(negedge clk);
        bus_sel = 0; rx_valid = 0;
        // model update
        if (!e_err) begin
            if (w) begin
                case (i)
                    4'd0: if (dl) m_divlo = d[7:0];
                    4'd1: if (dl) m_divhi = d[7:0]; else m_ien = d[7:0];
                    4'd3: m_lctl = d[7:0];
                    4'd4: m_mctl = d[7:0];
                    4'd7: m_scr = d[7:0];
                    4'd9: m_gctl = d[7:0];
                    default: ;
                endcase
            end else begin
                if (i == 4'd0 && !dl) m_rdy = 0;
                if (i == 4'd5) m_lsts = 8'h00;
            end
        end
        if (lp && e_tx) begin m_rbr = d[7:0]; m_rdy = 1; end      // R10
        else if (!lp && rxv) begin m_rbr = rxb; m_rdy = 1; end    // R9
        chk(bus_ack === 1'b1, "R1", int'(bus_ack), 1);
        chk(bus_err === e_err, "R2", int'(bus_err), int'(e_err));
        if (!w) chk(bus_rdata === {8'h00, e_rd}, e_err ? "R2" : rq, int'(bus_rdata), int'(e_rd));
        chk(tx_valid === e_tx, dl ? "R3" : "R4", int'(tx_valid), int'(e_tx));
        if (e_tx) chk(tx_byte === d[7:0], "R4", int'(tx_byte), int'(d[7:0]));
        chk(tx_event === (e_tx && m_ien[1]), "R11", int'(tx_event), int'(e_tx && m_ien[1]));
        chk(rx_event === (m_rdy && m_ien[0]), "R12", int'(rx_event), int'(m_rdy && m_ien[0]));
    endtask

    task automatic rx_in(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_byte = b;
        @(negedge clk);
        rx_valid = 0;
        if (!m_mctl[4]) begin m_rbr = b; m_rdy = 1; end
        chk(rx_event === (m_rdy && m_ien[0]), m_mctl[4] ? "R10" : "R12",
            int'(rx_event), int'(m_rdy && m_ien[0]));
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk(bus_ack === 0, "R1", int'(bus_ack), 0);
        chk(tx_valid === 0, "R4", int'(tx_valid), 0);
        chk(rx_event === 0, "R12", int'(rx_event), 0);
        // R8: sticky flags then cleared
        acc(0, 6'h14, 0, 1, 0, 0);
        acc(0, 6'h14, 0, 1, 0, 0);
        tx_idle = 1;
        acc(0, 6'h14, 0, 1, 0, 0);
        acc(1, 6'h14, 16'h00FF, 1, 0, 0);
        acc(0, 6'h14, 0, 1, 0, 0);
        tx_idle = 0;
        // R6: read-only slots and plain storage
        acc(0, 6'h08, 0, 1, 0, 0);
        acc(1, 6'h08, 16'h00FE, 1, 0, 0);
        acc(0, 6'h08, 0, 1, 0, 0);
        acc(1, 6'h18, 16'h0077, 1, 0, 0);
        acc(0, 6'h18, 0, 1, 0, 0);
        acc(1, 6'h24, 16'h00A9, 1, 0, 0);
        acc(0, 6'h24, 0, 1, 0, 0);
        // R7: upper byte dropped
        acc(1, 6'h1C, 16'hFFFF, 1, 0, 0);
        acc(0, 6'h1C, 0, 1, 0, 0);
        // R3: divisor access
        acc(1, 6'h0C, 16'h0080, 1, 0, 0);
        acc(0, 6'h00, 0, 1, 0, 0);
        acc(1, 6'h00, 16'h1234, 1, 0, 0);
        acc(1, 6'h04, 16'h0056, 1, 0, 0);
        acc(0, 6'h00, 0, 1, 0, 0);
        acc(0, 6'h04, 0, 1, 0, 0);
        acc(1, 6'h0C, 16'h0003, 1, 0, 0);
        // R5, R4, R11
        acc(1, 6'h04, 16'h0003, 1, 0, 0);
        acc(0, 6'h04, 0, 1, 0, 0);
        acc(1, 6'h00, 16'h00A5, 1, 0, 0);
        // R9, R12
        rx_in(8'h5A);
        acc(0, 6'h00, 0, 1, 0, 0);
        rx_in(8'h11);
        acc(0, 6'h00, 0, 1, 1, 8'h22);   // same-cycle arrival kept
        acc(0, 6'h00, 0, 1, 0, 0);
        // R10: loopback
        acc(1, 6'h10, 16'h0010, 1, 0, 0);
        rx_in(8'h99);
        acc(0, 6'h00, 0, 1, 0, 0);
        acc(1, 6'h00, 16'h00C3, 1, 1, 8'h44);
        acc(0, 6'h00, 0, 1, 0, 0);
        acc(1, 6'h10, 16'h0000, 1, 0, 0);
        // R2: error accesses have no effect
        acc(1, 6'h1C, 16'h0011, 0, 0, 0);
        acc(1, 6'h1E, 16'h0022, 1, 0, 0);
        acc(0, 6'h20, 0, 1, 0, 0);
        acc(1, 6'h28, 16'h0033, 1, 0, 0);
        acc(1, 6'h00, 16'h0044, 0, 0, 0);
        acc(0, 6'h1C, 0, 1, 0, 0);
        // random phase
        for (int n = 0; n < 600; n++) begin
            int unsigned r = $urandom % 100;
            tx_idle = $urandom % 2;
            if (r < 15) rx_in(8'($urandom));
            else begin
                logic [5:0] a = (r < 25) ? 6'($urandom) : {4'($urandom % 10), 2'b00};
                acc(r[0], a, 16'($urandom), ($urandom % 12) != 0,
                    ($urandom % 6) == 0, 8'($urandom));
            end
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule